// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block turns 32-bit device virtual addresses into physical addresses. It uses a single-level linear table held in memory. The table covers the whole 4 GiB virtual space in 4 KiB pages, which gives 1M descriptors of 32 bits each, 4 MiB in all. A configuration register holds the table start address. An eight-entry fully associative cache of recent translations answers repeated pages without going to memory. A cache miss issues exactly one descriptor read on a simple read port and waits for the data to return.

A descriptor with its valid flag set fills the cache and yields the physical address. A descriptor with the flag clear does not fill the cache. It produces a faulting response whose address points at a 128-byte-aligned protect buffer, so the access lands in the protect buffer instead of being aborted. The same cycle carries a one-cycle fault pulse with the page-aligned faulting address and the requester tag. Requests are served strictly in order, and at most one miss is outstanding.

Top module: `flat_iova_xlate`

## Requirements
- R1: After reset, reqReady is 1 and rspValid, memRdValid and faultPulse are 0.
- R2: A request that misses the cache raises memRdValid for exactly one cycle, in the cycle after acceptance. The read address is tableBase + iova[31:12]*4.
- R3: A returned descriptor with bit 1 set gives a response in the cycle after memRspValid. The response carries rspPa = {desc[31:12], iova[11:0]}, rspNonSec = desc[3], rspFault = 0 and rspId = the request's ID.
- R4: A request to a page held in the cache is answered in the cycle after acceptance, with no memory read and the same address and non-secure flag as the fill.
- R5: A descriptor with bit 1 clear gives rspFault = 1 and rspPa = {protect[31:7], 7'b0}. It does not fill the cache, so a later request to that page reads memory again.
- R6: A fault raises faultPulse for exactly one cycle, in the same cycle as the faulting response. faultVa = iova & 0xFFFFF000 and faultId = the request's ID.
- R7: reqReady is 0 from a miss's acceptance until its response, so responses come back in request order.
- R8: The cache has 8 entries replaced in round-robin order starting at entry 0. After 9 distinct pages are filled, the first page misses and the other eight hit.
- R9: A configuration write to offset 0x000 sets the table base and also invalidates every cache entry, restarting replacement at entry 0. Offset 0x214 sets the protect address.

Top module port list below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 12 | Configuration register offset |
| cfgWdata | input | 32 | Configuration write data |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqIova | input | 32 | Device virtual address |
| reqId | input | ID_W | Requester tag |
| rspValid | output | 1 | Response valid (one cycle) |
| rspPa | output | 32 | Physical or protect address |
| rspFault | output | 1 | Translation fault on this response |
| rspNonSec | output | 1 | Page marked non-secure |
| rspId | output | ID_W | Requester tag of the response |
| memRdValid | output | 1 | Descriptor read request |
| memRdAddr | output | 32 | Descriptor byte address |
| memRspValid | input | 1 | Descriptor read data valid |
| memRspData | input | 32 | Descriptor word |
| faultPulse | output | 1 | One-cycle fault indication |
| faultVa | output | 32 | Page-aligned faulting address |
| faultId | output | ID_W | Requester tag of the fault |

## Verification
The in-line properties check several rules on every cycle:
- a descriptor read lasts a single cycle;
- each miss is followed by its read;
- no two cache entries ever match the same page;
- the protect address is always 128-byte aligned;
- every fault pulse coincides with a faulting response and carries a page-aligned address.

Other behaviour depends on what the cache held earlier, so only the bench scenarios show it. This covers round-robin eviction after nine fills and the fact that a faulting page is never cached. It also covers invalidation on a table-base write, and translated values that match descriptors computed by the bench's own memory model.

// File: rtl/fxl_pkg.sv
package fxl_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int PROT_LSBS  = 7;
  localparam int VALID_BIT  = 1;
  localparam int NSEC_BIT   = 3;
  localparam logic [11:0] OFS_TABLE_BASE = 12'h000;
  localparam logic [11:0] OFS_PROTECT    = 12'h214;

  typedef struct packed {
    logic rspHit;
    logic latchReq;
    logic rspWalk;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RDREQ, ST_RDWAIT} fxlState_e;
endpackage

// File: rtl/fxl_ctrl.sv
module fxl_ctrl
  import fxl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         tlbHit,
  input  logic         memRspValid,
  output logic         reqReady,
  output logic         memRdValid,
  output ctrlStrobes_t strobes
);
  fxlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        if (tlbHit) strobes.rspHit = 1'b1;
        else begin
          strobes.latchReq = 1'b1;
          stateNext        = ST_RDREQ;
        end
      end
      ST_RDREQ: stateNext = ST_RDWAIT;
      ST_RDWAIT: if (memRspValid) begin
        strobes.rspWalk = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;

  assign reqReady   = (state == ST_IDLE);
  assign memRdValid = (state == ST_RDREQ);

  // R2
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |=> !memRdValid);
  // R2
  miss_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !tlbHit) |=> memRdValid);
  // R7
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !tlbHit) |=> !reqReady);
endmodule

// File: rtl/fxl_datapath.sv
module fxl_datapath
  import fxl_pkg::*;
#(
  parameter int ID_W        = 4,
  parameter int TLB_ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [11:0]        cfgAddr,
  input  logic [31:0]        cfgWdata,
  input  logic [VA_W-1:0]    reqIova,
  input  logic [ID_W-1:0]    reqId,
  input  ctrlStrobes_t       strobes,
  input  logic [31:0]        memRspData,
  output logic               tlbHit,
  output logic [VA_W-1:0]    memRdAddr,
  output logic               rspValid,
  output logic [VA_W-1:0]    rspPa,
  output logic               rspFault,
  output logic               rspNonSec,
  output logic [ID_W-1:0]    rspId,
  output logic               faultPulse,
  output logic [VA_W-1:0]    faultVa,
  output logic [ID_W-1:0]    faultId
);
  localparam int PTR_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(TLB_ENTRIES - 1);

  logic [31:0]         tableBase, protectAddr;
  logic [VPN_W-1:0]    tagVpn [TLB_ENTRIES];
  logic [VPN_W-1:0]    tagPpn [TLB_ENTRIES];
  logic [TLB_ENTRIES-1:0] tagNs, tagVld, hitVec;
  logic [PTR_W-1:0]    rrPtr;
  logic [VA_W-1:0]     pendIova;
  logic [ID_W-1:0]     pendId;
  logic [VPN_W-1:0]    hitPpn;
  logic                hitNs;
  logic                baseWrite, descOk;

  assign baseWrite = cfgWe && (cfgAddr == OFS_TABLE_BASE);
  assign descOk    = memRspData[VALID_BIT];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      tableBase   <= '0;
      protectAddr <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == OFS_TABLE_BASE) tableBase <= cfgWdata;
      if (cfgAddr == OFS_PROTECT)
        protectAddr <= {cfgWdata[31:PROT_LSBS], {PROT_LSBS{1'b0}}};
    end

  genvar g;
  generate
    for (g = 0; g < TLB_ENTRIES; g++) begin : g_slot
      assign hitVec[g] = tagVld[g] && (tagVpn[g] == reqIova[VA_W-1:PAGE_SHIFT]);
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          tagVld[g] <= 1'b0;
          tagVpn[g] <= '0;
          tagPpn[g] <= '0;
          tagNs[g]  <= 1'b0;
        end else if (baseWrite) begin
          tagVld[g] <= 1'b0;
        end else if (strobes.rspWalk && descOk && rrPtr == PTR_W'(g)) begin
          tagVld[g] <= 1'b1;
          tagVpn[g] <= pendIova[VA_W-1:PAGE_SHIFT];
          tagPpn[g] <= memRspData[31:PAGE_SHIFT];
          tagNs[g]  <= memRspData[NSEC_BIT];
        end
    end
  endgenerate

  always_comb begin
    hitPpn = '0;
    hitNs  = 1'b0;
    for (int i = 0; i < TLB_ENTRIES; i++)
      if (hitVec[i]) begin
        hitPpn = hitPpn | tagPpn[i];
        hitNs  = hitNs | tagNs[i];
      end
  end
  assign tlbHit = |hitVec;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rrPtr <= '0;
    else if (baseWrite) rrPtr <= '0;
    else if (strobes.rspWalk && descOk)
      rrPtr <= (rrPtr == LAST_SLOT) ? '0 : rrPtr + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      pendIova <= '0;
      pendId   <= '0;
    end else if (strobes.latchReq) begin
      pendIova <= reqIova;
      pendId   <= reqId;
    end

  assign memRdAddr = tableBase + {10'b0, pendIova[VA_W-1:PAGE_SHIFT], 2'b00};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspPa      <= '0;
      rspFault   <= 1'b0;
      rspNonSec  <= 1'b0;
      rspId      <= '0;
      faultPulse <= 1'b0;
      faultVa    <= '0;
      faultId    <= '0;
    end else begin
      rspValid   <= strobes.rspHit || strobes.rspWalk;
      faultPulse <= strobes.rspWalk && !descOk;
      if (strobes.rspHit) begin
        rspPa     <= {hitPpn, reqIova[PAGE_SHIFT-1:0]};
        rspFault  <= 1'b0;
        rspNonSec <= hitNs;
        rspId     <= reqId;
      end else if (strobes.rspWalk) begin
        rspId <= pendId;
        if (descOk) begin
          rspPa     <= {memRspData[31:PAGE_SHIFT], pendIova[PAGE_SHIFT-1:0]};
          rspFault  <= 1'b0;
          rspNonSec <= memRspData[NSEC_BIT];
        end else begin
          rspPa     <= protectAddr;
          rspFault  <= 1'b1;
          rspNonSec <= 1'b0;
          faultVa   <= {pendIova[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
          faultId   <= pendId;
        end
      end
    end

  // R8
  tlb_single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
  // R5
  protect_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspPa[PROT_LSBS-1:0] == '0));
  // R6
  fault_pairs_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> (rspValid && rspFault && faultVa[PAGE_SHIFT-1:0] == '0));
  // R6
  fault_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |=> !faultPulse);
endmodule

// File: rtl/flat_iova_xlate.sv
module flat_iova_xlate
  import fxl_pkg::*;
#(
  parameter int ID_W        = 4,
  parameter int TLB_ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [11:0]     cfgAddr,
  input  logic [31:0]     cfgWdata,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [31:0]     reqIova,
  input  logic [ID_W-1:0] reqId,
  output logic            rspValid,
  output logic [31:0]     rspPa,
  output logic            rspFault,
  output logic            rspNonSec,
  output logic [ID_W-1:0] rspId,
  output logic            memRdValid,
  output logic [31:0]     memRdAddr,
  input  logic            memRspValid,
  input  logic [31:0]     memRspData,
  output logic            faultPulse,
  output logic [31:0]     faultVa,
  output logic [ID_W-1:0] faultId
);
  ctrlStrobes_t strobes;
  logic         tlbHit;

  fxl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tlbHit(tlbHit),
    .memRspValid(memRspValid), .reqReady(reqReady),
    .memRdValid(memRdValid), .strobes(strobes)
  );

  fxl_datapath #(.ID_W(ID_W), .TLB_ENTRIES(TLB_ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .reqIova(reqIova), .reqId(reqId),
    .strobes(strobes), .memRspData(memRspData), .tlbHit(tlbHit),
    .memRdAddr(memRdAddr), .rspValid(rspValid), .rspPa(rspPa),
    .rspFault(rspFault), .rspNonSec(rspNonSec), .rspId(rspId),
    .faultPulse(faultPulse), .faultVa(faultVa), .faultId(faultId)
  );
endmodule

// File: tb/flat_iova_xlate_test.sv
module flat_iova_xlate_test;
  localparam int IDW = 4;
  logic clk = 0, rstN = 0;
  logic cfgWe = 0; logic [11:0] cfgAddr = 0; logic [31:0] cfgWdata = 0;
  logic reqValid = 0, reqReady; logic [31:0] reqIova = 0; logic [IDW-1:0] reqId = 0;
  logic rspValid, rspFault, rspNonSec; logic [31:0] rspPa; logic [IDW-1:0] rspId;
  logic memRdValid; logic [31:0] memRdAddr;
  logic memRspValid = 0; logic [31:0] memRspData = 0;
  logic faultPulse; logic [31:0] faultVa; logic [IDW-1:0] faultId;

  int nChecks = 0, nFails = 0;
  logic [31:0] mBase, mProt;
  logic [19:0] mVpn [8];
  logic [7:0]  mVld;
  int          mPtr;

  always #5 clk = ~clk;

  flat_iova_xlate #(.ID_W(IDW), .TLB_ENTRIES(8)) uut (.*);

  // bench memory: bit 1 (valid) clear when address bits 5:2 are all ones
  function automatic logic [31:0] descOf(input logic [31:0] a);
    logic [31:0] h;
    h = (a ^ (a >> 9)) * 32'h2545F491;
    h[1] = (a[5:2] != 4'hF);
    return h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit modelHit(input logic [19:0] vpn);
    for (int i = 0; i < 8; i++) if (mVld[i] && mVpn[i] == vpn) return 1;
    return 0;
  endfunction

  task automatic cfgWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); cfgWe = 1; cfgAddr = a; cfgWdata = d;
    @(negedge clk); cfgWe = 0;
    if (a == 12'h000) begin mBase = d; mVld = 0; mPtr = 0; end
    if (a == 12'h214) mProt = {d[31:7], 7'b0};
  endtask

  // returns 1 when served from the cache
  task automatic doReq(input logic [31:0] iova, input logic [IDW-1:0] id, output bit wasHit);
    logic [31:0] d, ea;
    bit expHit;
    expHit = modelHit(iova[31:12]);
    @(negedge clk);
    chk("R7 ready before accept", reqReady, 1);
    reqValid = 1; reqIova = iova; reqId = id;
    @(negedge clk); reqValid = 0;
    wasHit = expHit;
    if (expHit) begin
      d = descOf(mBase + {iova[31:12], 2'b00});
      chk("R4 hit response", rspValid, 1);
      chk("R4 hit no read", memRdValid, 0);
      chk("R4 hit pa", rspPa, {d[31:12], iova[11:0]});
      chk("R4 hit nonsec", rspNonSec, d[3]);
      chk("R4 hit id", rspId, id);
    end else begin
      ea = mBase + {iova[31:12], 2'b00};
      chk("R2 read issued", memRdValid, 1);
      chk("R2 read addr", memRdAddr, ea);
      chk("R7 busy", reqReady, 0);
      d = descOf(ea);
      repeat (1 + $urandom % 3) begin
        @(negedge clk);
        chk("R2 single read", memRdValid, 0);
        chk("R7 no early rsp", rspValid, 0);
      end
      memRspValid = 1; memRspData = d;
      @(negedge clk); memRspValid = 0;
      chk("R3 rsp valid", rspValid, 1);
      chk("R3 rsp id", rspId, id);
      if (d[1]) begin
        chk("R3 pa", rspPa, {d[31:12], iova[11:0]});
        chk("R3 nonsec", rspNonSec, d[3]);
        chk("R3 no fault", {rspFault, faultPulse}, 0);
        mVpn[mPtr] = iova[31:12]; mVld[mPtr] = 1; mPtr = (mPtr + 1) % 8;
      end else begin
        chk("R5 fault", rspFault, 1);
        chk("R5 protect pa", rspPa, mProt);
        chk("R6 pulse", faultPulse, 1);
        chk("R6 fault va", faultVa, iova & 32'hFFFFF000);
        chk("R6 fault id", faultId, id);
      end
    end
    @(negedge clk);
    chk("R6 pulse ends", {rspValid, faultPulse}, 0);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    bit h;
    logic [31:0] pool [12];
    void'($urandom(32'h1A2B3C));
    mBase = 0; mProt = 0; mVld = 0; mPtr = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready", reqReady, 1);
    chk("R1 idle outs", {rspValid, memRdValid, faultPulse}, 0);
    rstN = 1;
    cfgWrite(12'h214, 32'h8000_12FF);
    cfgWrite(12'h000, 32'h0040_0000);

    // R8: nine pages, then page 0 evicted, pages 1..8 still held
    for (int p = 0; p < 9; p++) doReq({12'h100, p[7:0], 12'h345}, 4'(p), h);
    doReq({12'h100, 8'd0, 12'h001}, 4'd9, h);
    chk("R8 first page evicted", h, 0);
    for (int p = 2; p < 9; p++) begin
      doReq({12'h100, p[7:0], 12'h0AA}, 4'd3, h);
      chk("R8 later pages held", h, 1);
    end

    // R5: faulting page (iova[15:12]=F with aligned base) never cached
    doReq(32'h0000_F123, 4'd5, h);
    doReq(32'h0000_F777, 4'd6, h);
    chk("R5 fault not filled", h, 0);

    // R9: base write invalidates
    doReq({12'h100, 8'd8, 12'h0}, 4'd1, h);
    chk("R9 held before base write", h, 1);
    cfgWrite(12'h000, 32'h0080_0000);
    doReq({12'h100, 8'd8, 12'h0}, 4'd1, h);
    chk("R9 invalidated by base write", h, 0);
    cfgWrite(12'h214, 32'hC000_0FFF);
    doReq(32'h1234_5F00, 4'd7, h);

    for (int i = 0; i < 12; i++) pool[i] = $urandom;
    for (int n = 0; n < 300; n++)
      doReq({pool[$urandom % 12][31:12], 12'($urandom)}, 4'($urandom), h);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule